// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block gathers a set of interrupt lines, 32 by default, into a small register bank on a simple memory-mapped read/write bus. Hardware event pulses latch into a cause register. Software can set any cause bit directly and can clear cause bits. For each bit, software chooses between two clear styles: writing a one clears the bit, or reading the bit clears it. A mask register can be written whole, or changed one bit at a time through separate set and clear ports. One registered interrupt output goes high while any cause bit is both pending and unmasked.

Every line uses the same bit position in all seven registers. The registers sit at consecutive word offsets, and software reaches them by a 3-bit word index:

| Offset | Register | Access |
|---|---|---|
| 0 | clear-style control | read/write |
| 1 | cause | read and clear |
| 2 | masked cause | read and clear |
| 3 | cause-set | write-only |
| 4 | mask value | read/write |
| 5 | mask-set | write-only |
| 6 | mask-clear | write-only |

Offset 7 is unused. A bus cycle is one clock cycle with select high. The write strobe chooses between a write and a read. Read data appears on the clock edge that accepts the read.

Top module: `irq_cause_bank`

## Requirements
- R1: Synchronous active-low reset clears the cause, control and mask registers, the read data and the interrupt output to zero.
- R2: A one-cycle high pulse on any hardware event input bit sets the matching cause bit at that clock edge.
- R3: Writing offset 3 sets every cause bit written as one, and bits written as zero leave their cause bits unchanged.
- R4: A cause bit whose control bit (offset 0) is 0 clears when a one is written to that bit at offset 1 or offset 2. Writing zero to it has no effect, and reading it has no effect.
- R5: A cause bit whose control bit is 1 clears when a read of offset 1 is accepted, and the read returns the value from before the clear. Writing one to such a bit has no effect.
- R6: Offset 2 reads as cause AND NOT mask. An accepted read of offset 2 clears only those control-1 bits that are unmasked. Writes to offset 2 follow the R4 rule.
- R7: Writing offset 5 sets the mask bits written as one, and writing offset 6 clears the mask bits written as one. Zero bits leave the mask unchanged. Writing offset 4 loads the whole mask, and reading offset 4 returns the mask.
- R8: When a set (hardware event or cause-set) and a clear reach the same cause bit in the same cycle, the bit ends up set.
- R9: The interrupt output is a register. After every clock edge it is high exactly when cause AND NOT mask is nonzero.
- R10: Reads of offsets 3, 5, 6 and 7 return zero, and a write to offset 7 changes no register.
- R11: Read data is loaded only on an accepted read, is valid from the edge that accepts the read, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_event_i | input | NUM_LINES | Hardware event pulses, one per line |
| bus_sel_i | input | 1 | Bus cycle valid |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register word offset |
| bus_wdata_i | input | NUM_LINES | Write data |
| bus_rdata_o | output | NUM_LINES | Read data, registered |
| irq_o | output | 1 | Interrupt request, registered |

## Verification
On every cycle the bound checker verifies the following:
- hardware events always land in the cause register;
- an unqualified cause read empties the read-clear bits and leaves the write-one-clear bits alone;
- the mask set and clear ports take effect;
- the write-only offsets read as zero;
- read data holds between reads;
- the interrupt output tracks the masked cause.

Some behaviour only the bench scenarios can show. These are the values returned by each view: the value from before a clear, and the masked-cause view with its rule that a read clears only unmasked bits. They also include the set-wins collision on one bit, the selective effect of writing ones and zeros, and the proof that offset 7 writes change nothing.

// File: rtl/irq_bank_pkg.sv
// Shared definitions for the interrupt cause/mask bank.
// Assumes a 3-bit word index selects one of seven registers (offset 7 unused).
package irq_bank_pkg;

    localparam int ICB_ADDR_W = 3;

    typedef enum logic [ICB_ADDR_W-1:0] {
        OFS_CLR_STYLE = 3'd0,
        OFS_CAUSE     = 3'd1,
        OFS_MASKED    = 3'd2,
        OFS_CAUSE_SET = 3'd3,
        OFS_MASK      = 3'd4,
        OFS_MASK_SET  = 3'd5,
        OFS_MASK_CLR  = 3'd6,
        OFS_SPARE     = 3'd7
    } icb_ofs_e;

    typedef struct packed {
        logic rd_any;
        logic rd_cause;
        logic rd_masked;
        logic wr_style;
        logic wr_cause;
        logic wr_masked;
        logic wr_set;
        logic wr_mask;
        logic wr_mask_set;
        logic wr_mask_clr;
    } icb_strobe_t;

endpackage

// File: rtl/icb_bus_decode.sv
// Turns a single-cycle bus access into one-hot register strobes.
// Assumes sel qualifies wr and addr; offset 7 produces no write strobe.
module icb_bus_decode
    import irq_bank_pkg::*;
(
    input  logic                  sel_i,
    input  logic                  wr_i,
    input  logic [ICB_ADDR_W-1:0] addr_i,
    output icb_strobe_t           stb_o
);

    icb_ofs_e ofs;
    logic     rd_acc;
    logic     wr_acc;

    // Classify the access and select the addressed register.
    always_comb begin
        ofs               = icb_ofs_e'(addr_i);
        rd_acc            = sel_i & ~wr_i;
        wr_acc            = sel_i & wr_i;
        stb_o             = '0;
        stb_o.rd_any      = rd_acc;
        stb_o.rd_cause    = rd_acc & (ofs == OFS_CAUSE);
        stb_o.rd_masked   = rd_acc & (ofs == OFS_MASKED);
        stb_o.wr_style    = wr_acc & (ofs == OFS_CLR_STYLE);
        stb_o.wr_cause    = wr_acc & (ofs == OFS_CAUSE);
        stb_o.wr_masked   = wr_acc & (ofs == OFS_MASKED);
        stb_o.wr_set      = wr_acc & (ofs == OFS_CAUSE_SET);
        stb_o.wr_mask     = wr_acc & (ofs == OFS_MASK);
        stb_o.wr_mask_set = wr_acc & (ofs == OFS_MASK_SET);
        stb_o.wr_mask_clr = wr_acc & (ofs == OFS_MASK_CLR);
    end

endmodule

// File: rtl/icb_cause_array.sv
// Holds the clear-style control register and the cause bits.
// For each line: a set beats any clear in the same cycle. A style-0 bit
// clears on a written one. A style-1 bit clears on an accepted cause read,
// or on a masked-cause read while it is unmasked.
// Assumes at most one strobe from the decoder is active per cycle.
module icb_cause_array
    import irq_bank_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  icb_strobe_t          stb_i,
    input  logic [NUM_LINES-1:0] wdata_i,
    input  logic [NUM_LINES-1:0] hw_event_i,
    input  logic [NUM_LINES-1:0] mask_i,
    output logic [NUM_LINES-1:0] style_q_o,
    output logic [NUM_LINES-1:0] cause_q_o,
    output logic [NUM_LINES-1:0] cause_d_o
);

    logic [NUM_LINES-1:0] style_q;
    logic [NUM_LINES-1:0] cause_q;
    logic [NUM_LINES-1:0] cause_d;

    // Clear-style control register, written whole.
    always_ff @(posedge clk) begin
        if (!rst_n)              style_q <= '0;
        else if (stb_i.wr_style) style_q <= wdata_i;
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic set_i;
        logic clr_wr_i;
        logic clr_rd_i;

        // Work out the set and the two clear sources for this line.
        always_comb begin
            set_i    = hw_event_i[i] | (stb_i.wr_set & wdata_i[i]);
            clr_wr_i = ~style_q[i] & wdata_i[i] & (stb_i.wr_cause | stb_i.wr_masked);
            clr_rd_i = style_q[i] & (stb_i.rd_cause | (stb_i.rd_masked & ~mask_i[i]));
            cause_d[i] = set_i | (cause_q[i] & ~(clr_wr_i | clr_rd_i));
        end

        // Cause bit storage.
        always_ff @(posedge clk) begin
            if (!rst_n) cause_q[i] <= 1'b0;
            else        cause_q[i] <= cause_d[i];
        end
    end

    assign style_q_o = style_q;
    assign cause_q_o = cause_q;
    assign cause_d_o = cause_d;

endmodule

// File: rtl/icb_mask_reg.sv
// Mask register with a whole-word write port plus separate bitwise set and
// clear ports. Assumes only one of the three write strobes is high per cycle.
module icb_mask_reg
    import irq_bank_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  icb_strobe_t          stb_i,
    input  logic [NUM_LINES-1:0] wdata_i,
    output logic [NUM_LINES-1:0] mask_q_o,
    output logic [NUM_LINES-1:0] mask_d_o
);

    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] mask_d;

    // Next mask value from whichever port is being written.
    always_comb begin
        mask_d = mask_q;
        if (stb_i.wr_mask)     mask_d = wdata_i;
        if (stb_i.wr_mask_set) mask_d = mask_q | wdata_i;
        if (stb_i.wr_mask_clr) mask_d = mask_q & ~wdata_i;
    end

    // Mask storage.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign mask_q_o = mask_q;
    assign mask_d_o = mask_d;

endmodule

// File: rtl/irq_cause_bank.sv
// Top of the interrupt cause/mask bank: decode, cause and mask storage,
// read mux with registered data, and registered interrupt output.
// Assumes single-cycle bus accesses. Read data is loaded on the accepting
// edge and holds until the next read.
module irq_cause_bank
    import irq_bank_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LINES-1:0]  hw_event_i,
    input  logic                  bus_sel_i,
    input  logic                  bus_wr_i,
    input  logic [ICB_ADDR_W-1:0] bus_addr_i,
    input  logic [NUM_LINES-1:0]  bus_wdata_i,
    output logic [NUM_LINES-1:0]  bus_rdata_o,
    output logic                  irq_o
);

    icb_strobe_t          stb;
    logic [NUM_LINES-1:0] style_q;
    logic [NUM_LINES-1:0] cause_q;
    logic [NUM_LINES-1:0] cause_d;
    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] mask_d;
    logic [NUM_LINES-1:0] rd_mux;
    logic [NUM_LINES-1:0] rdata_q;
    logic                 irq_q;

    icb_bus_decode u_decode (
        .sel_i  (bus_sel_i),
        .wr_i   (bus_wr_i),
        .addr_i (bus_addr_i),
        .stb_o  (stb)
    );

    icb_cause_array #(.NUM_LINES(NUM_LINES)) u_cause (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb_i      (stb),
        .wdata_i    (bus_wdata_i),
        .hw_event_i (hw_event_i),
        .mask_i     (mask_q),
        .style_q_o  (style_q),
        .cause_q_o  (cause_q),
        .cause_d_o  (cause_d)
    );

    icb_mask_reg #(.NUM_LINES(NUM_LINES)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb_i    (stb),
        .wdata_i  (bus_wdata_i),
        .mask_q_o (mask_q),
        .mask_d_o (mask_d)
    );

    // Select read data; write-only and spare offsets read as zero.
    always_comb begin
        unique case (icb_ofs_e'(bus_addr_i))
            OFS_CLR_STYLE: rd_mux = style_q;
            OFS_CAUSE:     rd_mux = cause_q;
            OFS_MASKED:    rd_mux = cause_q & ~mask_q;
            OFS_MASK:      rd_mux = mask_q;
            default:       rd_mux = '0;
        endcase
    end

    // Capture the pre-clear read value on an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n)          rdata_q <= '0;
        else if (stb.rd_any) rdata_q <= rd_mux;
    end

    // Interrupt request follows the masked cause being loaded this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(cause_d & ~mask_d);
    end

    assign bus_rdata_o = rdata_q;
    assign irq_o       = irq_q;

endmodule

// File: rtl/irq_cause_bank_checker.sv
// Protocol and state checks for irq_cause_bank; attached by bind below.
// Assumes internal cause, mask and style registers are passed in by the bind.
module irq_cause_bank_checker
    import irq_bank_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_LINES-1:0]  hw_event_i,
    input logic                  bus_sel_i,
    input logic                  bus_wr_i,
    input logic [ICB_ADDR_W-1:0] bus_addr_i,
    input logic [NUM_LINES-1:0]  bus_wdata_i,
    input logic [NUM_LINES-1:0]  bus_rdata_o,
    input logic                  irq_o,
    input logic [NUM_LINES-1:0]  cause_q,
    input logic [NUM_LINES-1:0]  mask_q,
    input logic [NUM_LINES-1:0]  style_q
);

    logic rd_acc;
    logic wr_acc;
    logic wo_read;
    assign rd_acc  = bus_sel_i & ~bus_wr_i;
    assign wr_acc  = bus_sel_i & bus_wr_i;
    assign wo_read = rd_acc & ((bus_addr_i == 3'd3) | (bus_addr_i == 3'd5) |
                               (bus_addr_i == 3'd6) | (bus_addr_i == 3'd7));

    // R1: reset empties the state registers
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (cause_q == '0 && mask_q == '0 && style_q == '0 && !irq_o));

    // R2 / R8: every event pulse is latched regardless of any clear
    p_event_latched_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_event_i) |=> ((cause_q & $past(hw_event_i)) == $past(hw_event_i)));

    // R5: an event-free cause read empties read-clear bits
    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && bus_addr_i == 3'd1 && hw_event_i == '0)
        |=> ((cause_q & $past(style_q & cause_q)) == '0));

    // R4: a read never drops a write-one-clear bit
    p_read_keeps_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> (($past(cause_q & ~style_q) & ~cause_q) == '0));

    // R7: mask-set port sets the written bits
    p_mask_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && bus_addr_i == 3'd5)
        |=> ((mask_q & $past(bus_wdata_i)) == $past(bus_wdata_i)));

    // R7: mask-clear port clears the written bits
    p_mask_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && bus_addr_i == 3'd6) |=> ((mask_q & $past(bus_wdata_i)) == '0));

    // R9: interrupt output matches the masked cause after each edge
    p_irq_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_o == |(cause_q & ~mask_q)));

    // R10: write-only and spare offsets read as zero
    p_wo_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wo_read |=> (bus_rdata_o == '0));

    // R11: read data holds when no read is accepted
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_acc && rst_n) |=> $stable(bus_rdata_o));

endmodule

bind irq_cause_bank irq_cause_bank_checker #(.NUM_LINES(NUM_LINES)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_event_i  (hw_event_i),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .cause_q     (cause_q),
    .mask_q      (mask_q),
    .style_q     (style_q)
);

// File: tb/tb_irq_cause_bank.sv
`timescale 1ns/1ps
module tb_irq_cause_bank;

    localparam int NL = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] hw_event = '0;
    logic          sel = 1'b0;
    logic          wr = 1'b0;
    logic [2:0]    addr = '0;
    logic [NL-1:0] wdata = '0;
    logic [NL-1:0] rdata;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic rd_fire = 1'b0;

    logic [NL-1:0] exp_q[$];
    string         tag_q[$];

    always #10 clk = ~clk;   // 50 MHz

    irq_cause_bank #(.NUM_LINES(NL)) dut (
        .clk(clk), .rst_n(rst_n), .hw_event_i(hw_event), .bus_sel_i(sel),
        .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [NL-1:0] act, input logic [NL-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Driver: one write cycle
    task automatic bus_write(input logic [2:0] a, input logic [NL-1:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    // Driver: one read cycle, expected value pushed to the scoreboard
    task automatic bus_read(input logic [2:0] a, input logic [NL-1:0] e, input string tag);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic pulse(input logic [NL-1:0] v);
        @(negedge clk);
        hw_event = v;
        @(negedge clk);
        hw_event = '0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        check(tag, {31'd0, irq}, {31'd0, e});
    endtask

    // Monitor: marks reads accepted at an edge
    always @(posedge clk) rd_fire <= rst_n & sel & ~wr;

    // Monitor: compares read data against the scoreboard
    always @(negedge clk) begin
        if (rd_fire) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected read data", rdata, 'x);
            end else begin
                logic [NL-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, rdata, e);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 irq in reset", {31'd0, irq}, 32'd0);
        check("R1 rdata in reset", rdata, 32'd0);
        rst_n = 1'b1;
        bus_read(3'd0, 32'h0, "R1 style reset");
        bus_read(3'd1, 32'h0, "R1 cause reset");
        bus_read(3'd4, 32'h0, "R1 mask reset");
        chk_irq(1'b0, "R1 irq after reset");

        // R3 cause-set
        bus_write(3'd3, 32'h0000_00F0);
        bus_read(3'd1, 32'h0000_00F0, "R3 cause-set bits");
        chk_irq(1'b1, "R9 irq with unmasked cause");
        bus_read(3'd3, 32'h0, "R10 cause-set reads zero");
        bus_write(3'd3, 32'h0);
        bus_read(3'd1, 32'h0000_00F0, "R3 zero write no effect");

        // R4 write-one-clear
        bus_write(3'd1, 32'h0000_0030);
        bus_read(3'd1, 32'h0000_00C0, "R4 w1c partial clear");
        bus_read(3'd1, 32'h0000_00C0, "R4 read does not clear");
        bus_write(3'd1, 32'h0000_00C0);
        bus_read(3'd1, 32'h0, "R4 w1c full clear");
        chk_irq(1'b0, "R9 irq drops");

        // R5 clear-on-read for upper half
        bus_write(3'd0, 32'hFFFF_0000);
        bus_read(3'd0, 32'hFFFF_0000, "R5 style readback");
        bus_write(3'd3, 32'h0003_0003);
        bus_write(3'd1, 32'hFFFF_FFFF);
        bus_read(3'd1, 32'h0003_0000, "R5 write ignored on read-clear bits");
        bus_read(3'd1, 32'h0, "R5 cleared by read");

        // R2 hardware events
        pulse(32'h0000_0020);
        pulse(32'h0010_0000);
        bus_read(3'd1, 32'h0010_0020, "R2 events latched");
        bus_read(3'd1, 32'h0000_0020, "R2 read-clear event bit gone");
        bus_write(3'd1, 32'h0000_0020);

        // R7 mask ports
        bus_write(3'd5, 32'h0000_000F);
        bus_read(3'd4, 32'h0000_000F, "R7 mask set");
        bus_write(3'd6, 32'h0000_0003);
        bus_read(3'd4, 32'h0000_000C, "R7 mask clear");
        bus_write(3'd4, 32'h0000_0100);
        bus_read(3'd4, 32'h0000_0100, "R7 mask direct write");
        bus_read(3'd5, 32'h0, "R10 mask-set reads zero");
        bus_read(3'd6, 32'h0, "R10 mask-clear reads zero");

        // R6 masked cause view
        bus_write(3'd3, 32'h0001_0101);
        bus_read(3'd2, 32'h0001_0001, "R6 masked view");
        bus_read(3'd1, 32'h0000_0101, "R6 masked read cleared unmasked read-clear bit");
        chk_irq(1'b1, "R9 irq from unmasked bit");
        bus_write(3'd2, 32'h0000_0001);
        bus_read(3'd2, 32'h0, "R6 write to masked view clears");
        chk_irq(1'b0, "R9 irq low with only masked cause");
        bus_write(3'd3, 32'h0100_0000);
        bus_write(3'd5, 32'h0100_0000);
        bus_read(3'd2, 32'h0, "R6 masked view hides masked bits");
        bus_read(3'd1, 32'h0100_0100, "R6 masked read kept masked read-clear bit");
        bus_read(3'd1, 32'h0000_0100, "R5 cause read clears");
        bus_write(3'd1, 32'h0000_0100);
        bus_write(3'd4, 32'h0);

        // R8 set beats clear
        bus_write(3'd3, 32'h0000_0008);
        @(negedge clk);
        hw_event = 32'h0000_0008; sel = 1'b1; wr = 1'b1; addr = 3'd1; wdata = 32'h0000_0008;
        @(negedge clk);
        hw_event = '0; sel = 1'b0; wr = 1'b0; wdata = '0;
        bus_read(3'd1, 32'h0000_0008, "R8 event beats w1c");
        bus_write(3'd3, 32'h0002_0000);
        @(negedge clk);
        hw_event = 32'h0002_0000; sel = 1'b1; wr = 1'b0; addr = 3'd1;
        exp_q.push_back(32'h0002_0008); tag_q.push_back("R8 read during event");
        @(negedge clk);
        hw_event = '0; sel = 1'b0;
        bus_read(3'd1, 32'h0002_0008, "R8 event beats read-clear");
        bus_read(3'd1, 32'h0000_0008, "R5 later read clears");

        // R9 irq follows mask
        chk_irq(1'b1, "R9 irq pending");
        bus_write(3'd5, 32'h0000_0008);
        chk_irq(1'b0, "R9 irq masked");
        bus_write(3'd6, 32'h0000_0008);
        chk_irq(1'b1, "R9 irq unmasked");

        // R10 spare offset
        bus_write(3'd7, 32'hFFFF_FFFF);
        bus_read(3'd7, 32'h0, "R10 spare reads zero");
        bus_read(3'd1, 32'h0000_0008, "R10 spare write left cause");
        bus_read(3'd4, 32'h0, "R10 spare write left mask");
        bus_read(3'd0, 32'hFFFF_0000, "R10 spare write left style");
        bus_write(3'd1, 32'h0000_0008);
        chk_irq(1'b0, "R9 irq after final clear");

        repeat (3) @(negedge clk);
        check("R11 all reads returned", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule